// File: doc/BRIEF.md
# Serial Programming Port with Control-Bit Routing

This block receives configuration words for a frequency synthesizer over a three-wire serial link: a data line, a serial clock and a latch strobe. All three wires are brought into the system clock domain through a synchronizer chain. Rising edges of the serial clock are detected there and shift one data bit each into a 19-bit shift register. A rising edge of the latch strobe copies the register into one of two output latch groups. The bit shifted in last, the control bit, picks the group.

The reference group holds a 14-bit reference ratio and three one-bit flags: prescaler modulus select, phase-detector polarity and monitor-output select. The divider group holds a 7-bit swallow count and an 11-bit main count. Each group has a one-cycle done strobe. A ratio or main count below 3 is still latched, but a level flag stays raised beside it until the next load of that group. The latched fields are plain levels with no handshake. A downstream consumer reads them at will, and there is no back-pressure: a new load always overwrites the group it selects.

Top module: `serial_load_port`

## Requirements
- R1: Each rising edge of ser_clk while ser_latch is low shifts ser_data into the register, most significant bit first. The last bit sent lands at position 1, and the first of 19 bits sent lands at position 19.
- R2: A load with position 1 equal to 1 updates the reference group. ref_ratio comes from positions 2 to 15, with position 2 as its least significant bit. pre_sel comes from position 16, pd_polarity from position 17 and mon_sel from position 18.
- R3: Position 19 has no effect on a reference-group load.
- R4: A load with position 1 equal to 0 updates the divider group. swallow_cnt comes from positions 2 to 8 and main_cnt from positions 9 to 19, least significant bit first in both.
- R5: Each rising edge of ser_latch gives exactly one update of the selected group and leaves the other group unchanged. The matching done output is high for exactly one clk cycle.
- R6: Rising edges of ser_clk while ser_latch is high do not change the shift register.
- R7: ref_bad is 1 after a reference load whose ratio is below 3, and 0 after one whose ratio is 3 or more. The ratio is latched in both cases.
- R8: main_bad is 1 after a divider load whose main count is below 3, and 0 otherwise. The count is latched in both cases.
- R9: After reset, all latched fields, both flags and both done outputs are 0.
- R10: With the default two synchronizer stages, a done output is high during the clk cycle that follows the third rising clk edge after ser_latch rises. It is low after the second edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_data | input | 1 | Serial data line |
| ser_clk | input | 1 | Serial shift clock, sampled by clk |
| ser_latch | input | 1 | Latch strobe; a rising edge transfers the register |
| ref_ratio | output | 14 | Latched reference ratio |
| pre_sel | output | 1 | Latched prescaler modulus select |
| pd_polarity | output | 1 | Latched phase-detector polarity |
| mon_sel | output | 1 | Latched monitor-output select |
| ref_bad | output | 1 | Reference ratio below 3 |
| ref_done | output | 1 | One-cycle strobe on a reference load |
| swallow_cnt | output | 7 | Latched swallow count |
| main_cnt | output | 11 | Latched main count |
| main_bad | output | 1 | Main count below 3 |
| div_done | output | 1 | One-cycle strobe on a divider load |

## Verification
A register bit that is off by one, or a wrong control-bit decode, shows up in the field values when the next done strobe fires. That strobe comes three clk cycles after the latch edge. A shift taken while the strobe is high stays hidden until a later load reuses the register without new bits. A repeated load with clock glitches injected aims at exactly that case. A wrong or doubled strobe appears at the done ports at once, and the other group's fields are compared on every load to catch writes that land in the wrong group.

// File: rtl/sl_pkg.sv
package sl_pkg;
  localparam int SR_W = 19;
  localparam int R_W  = 14;
  localparam int A_W  = 7;
  localparam int N_W  = 11;

  typedef struct packed {
    logic [R_W-1:0] ratio;
    logic           pre_sel;
    logic           pd_pol;
    logic           mon_sel;
  } ref_set_t;

  typedef struct packed {
    logic [A_W-1:0] swallow;
    logic [N_W-1:0] main;
  } div_set_t;
endpackage

// File: rtl/sl_sync.sv
module sl_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= '0;
    end else begin
      st[0] <= d;
      for (int s = 1; s < STAGES; s++) st[s] <= st[s-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/sl_edge.sv
module sl_edge #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise
);
  logic [W-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '0;
    else        prev <= lvl;
  end

  assign rise = lvl & ~prev;

  // R5: an edge is reported for a single cycle only
  p_rise_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rise != '0) |=> ((rise & $past(rise)) == '0));
endmodule

// File: rtl/sl_shifter.sv
module sl_shifter #(
  parameter int SR_W = 19
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clk_rise,
  input  logic            latch_lvl,
  input  logic            din,
  output logic [SR_W-1:0] sr
);
  logic shift_en;
  assign shift_en = clk_rise & ~latch_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sr <= '0;
    else if (shift_en) sr <= {sr[SR_W-2:0], din};
  end

  // R6: register frozen while the latch strobe is high
  p_hold_while_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    latch_lvl |=> $stable(sr));

  // R1: register moves only on a detected serial clock edge
  p_shift_on_edge_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_rise |=> $stable(sr));
endmodule

// File: rtl/sl_latch_sets.sv
module sl_latch_sets
  import sl_pkg::*;
#(
  parameter int MIN_RATIO = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [SR_W-1:0] sr,
  output ref_set_t        ref_q,
  output logic            ref_bad,
  output logic            ref_done,
  output div_set_t        div_q,
  output logic            div_bad,
  output logic            div_done
);
  localparam logic [R_W-1:0] R_MIN = R_W'(MIN_RATIO);
  localparam logic [N_W-1:0] N_MIN = N_W'(MIN_RATIO);

  ref_set_t ref_nx;
  div_set_t div_nx;
  logic     sel_ref;
  logic     unused_top;

  always_comb begin
    sel_ref        = sr[0];
    ref_nx.ratio   = sr[R_W:1];
    ref_nx.pre_sel = sr[R_W+1];
    ref_nx.pd_pol  = sr[R_W+2];
    ref_nx.mon_sel = sr[R_W+3];
    div_nx.swallow = sr[A_W:1];
    div_nx.main    = sr[A_W+N_W:A_W+1];
  end

  assign unused_top = sr[SR_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q    <= '0;
      div_q    <= '0;
      ref_bad  <= 1'b0;
      div_bad  <= 1'b0;
      ref_done <= 1'b0;
      div_done <= 1'b0;
    end else begin
      ref_done <= 1'b0;
      div_done <= 1'b0;
      if (load) begin
        if (sel_ref) begin
          ref_q    <= ref_nx;
          ref_bad  <= (ref_nx.ratio < R_MIN);
          ref_done <= 1'b1;
        end else begin
          div_q    <= div_nx;
          div_bad  <= (div_nx.main < N_MIN);
          div_done <= 1'b1;
        end
      end
    end
  end

  // R5: never both groups in one cycle
  p_one_group_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ref_done, div_done}));
  // R5: a latch edge always yields a done strobe
  p_load_gives_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (ref_done || div_done));
  // R5: reference fields move only together with their strobe
  p_ref_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ref_q) |-> ref_done);
  // R5: divider fields move only together with their strobe
  p_div_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(div_q) |-> div_done);
  // R5: strobes last one cycle
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_done || div_done) |=> !(ref_done || div_done));
endmodule

// File: rtl/serial_load_port.sv
module serial_load_port
  import sl_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_RATIO   = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ser_data,
  input  logic           ser_clk,
  input  logic           ser_latch,
  output logic [R_W-1:0] ref_ratio,
  output logic           pre_sel,
  output logic           pd_polarity,
  output logic           mon_sel,
  output logic           ref_bad,
  output logic           ref_done,
  output logic [A_W-1:0] swallow_cnt,
  output logic [N_W-1:0] main_cnt,
  output logic           main_bad,
  output logic           div_done
);
  logic [2:0]      lvl;
  logic [1:0]      rise;
  logic [SR_W-1:0] sr;
  ref_set_t        ref_q;
  div_set_t        div_q;

  sl_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({ser_latch, ser_clk, ser_data}),
    .q(lvl)
  );

  sl_edge #(.W(2)) u_edge (
    .clk(clk), .rst_n(rst_n),
    .lvl(lvl[2:1]),
    .rise(rise)
  );

  sl_shifter #(.SR_W(SR_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .clk_rise(rise[0]),
    .latch_lvl(lvl[2]),
    .din(lvl[0]),
    .sr(sr)
  );

  sl_latch_sets #(.MIN_RATIO(MIN_RATIO)) u_sets (
    .clk(clk), .rst_n(rst_n),
    .load(rise[1]),
    .sr(sr),
    .ref_q(ref_q), .ref_bad(ref_bad), .ref_done(ref_done),
    .div_q(div_q), .div_bad(main_bad), .div_done(div_done)
  );

  assign ref_ratio   = ref_q.ratio;
  assign pre_sel     = ref_q.pre_sel;
  assign pd_polarity = ref_q.pd_pol;
  assign mon_sel     = ref_q.mon_sel;
  assign swallow_cnt = div_q.swallow;
  assign main_cnt    = div_q.main;
endmodule

// File: tb/serial_load_port_test.sv
module serial_load_port_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ser_data = 1'b0, ser_clk = 1'b0, ser_latch = 1'b0;
  logic [13:0] ref_ratio;
  logic pre_sel, pd_polarity, mon_sel, ref_bad, ref_done;
  logic [6:0] swallow_cnt;
  logic [10:0] main_cnt;
  logic main_bad, div_done;

  always #2 clk = ~clk;

  serial_load_port uut (
    .clk(clk), .rst_n(rst_n), .ser_data(ser_data), .ser_clk(ser_clk),
    .ser_latch(ser_latch), .ref_ratio(ref_ratio), .pre_sel(pre_sel),
    .pd_polarity(pd_polarity), .mon_sel(mon_sel), .ref_bad(ref_bad),
    .ref_done(ref_done), .swallow_cnt(swallow_cnt), .main_cnt(main_cnt),
    .main_bad(main_bad), .div_done(div_done)
  );

  typedef struct packed {
    logic [13:0] r; logic sw; logic fc; logic lds; logic rbad;
    logic [6:0] a; logic [10:0] n; logic nbad; logic is_ref;
  } exp_t;

  exp_t q[$];
  exp_t model;
  int errors = 0, checks = 0, dones = 0, loads = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // R1: word bit k-1 is position k; position 19 goes out first
  task automatic shift_word(input logic [18:0] w);
    for (int i = 18; i >= 0; i--) begin
      ser_data = w[i];
      tick(3); ser_clk = 1'b1;
      tick(3); ser_clk = 1'b0;
      tick(2);
    end
  endtask

  task automatic latch(input int glitches);
    q.push_back(model);
    loads++;
    ser_latch = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk(!ref_done && !div_done, "R10", "done early", int'(ref_done | div_done), 0);
    @(posedge clk); @(negedge clk);
    if (model.is_ref) chk(ref_done, "R10", "ref_done latency", int'(ref_done), 1);
    else              chk(div_done, "R10", "div_done latency", int'(div_done), 1);
    tick(3);
    // R6: serial clock pulses while the strobe is high
    for (int g = 0; g < glitches; g++) begin
      ser_data = 1'b1;
      tick(3); ser_clk = 1'b1;
      tick(3); ser_clk = 1'b0;
      tick(2);
    end
    ser_data = 1'b0;
    ser_latch = 1'b0;
    tick(6);
  endtask

  task automatic load_ref(input logic [13:0] r, input logic sw, input logic fc,
                          input logic lds, input logic p19);
    shift_word({p19, lds, fc, sw, r, 1'b1});
    model.r = r; model.sw = sw; model.fc = fc; model.lds = lds;
    model.rbad = (r < 14'd3); model.is_ref = 1'b1;
    latch(0);
  endtask

  task automatic load_div(input logic [6:0] a, input logic [10:0] n, input int glitches);
    shift_word({n, a, 1'b0});
    model.a = a; model.n = n; model.nbad = (n < 11'd3); model.is_ref = 1'b0;
    latch(glitches);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && (ref_done || div_done)) begin
      dones++;
      if (q.size() == 0) begin
        chk(1'b0, "R5", "unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(ref_done == e.is_ref, "R5", "group strobe", int'(ref_done), int'(e.is_ref));
        chk(ref_ratio == e.r, "R2", "ref_ratio", int'(ref_ratio), int'(e.r));
        chk(pre_sel == e.sw, "R2", "pre_sel", int'(pre_sel), int'(e.sw));
        chk(pd_polarity == e.fc, "R2", "pd_polarity", int'(pd_polarity), int'(e.fc));
        chk(mon_sel == e.lds, "R3", "mon_sel", int'(mon_sel), int'(e.lds));
        chk(ref_bad == e.rbad, "R7", "ref_bad", int'(ref_bad), int'(e.rbad));
        chk(swallow_cnt == e.a, "R4", "swallow_cnt", int'(swallow_cnt), int'(e.a));
        chk(main_cnt == e.n, "R4", "main_cnt", int'(main_cnt), int'(e.n));
        chk(main_bad == e.nbad, "R8", "main_bad", int'(main_bad), int'(e.nbad));
      end
    end
  end

  initial begin
    model = '0;
    tick(5);
    rst_n = 1'b1;
    tick(2);
    // R9: reset state
    chk({ref_ratio, pre_sel, pd_polarity, mon_sel, ref_bad, ref_done,
         swallow_cnt, main_cnt, main_bad, div_done} == '0, "R9", "reset outputs", 1, 0);

    load_ref(14'd100, 1'b1, 1'b0, 1'b1, 1'b0);
    load_div(7'd5, 11'd1000, 0);
    load_ref(14'd2, 1'b0, 1'b1, 1'b0, 1'b1);       // R7 bad, R3 position 19 set
    load_ref(14'd3, 1'b1, 1'b1, 1'b0, 1'b1);       // R7 boundary
    load_ref(14'h3FFF, 1'b1, 1'b1, 1'b1, 1'b1);
    load_div(7'd0, 11'd2, 0);                      // R8 bad
    load_div(7'd127, 11'd3, 0);                    // R8 boundary
    load_div(7'h55, 11'd2047, 2);                  // R6 glitches on strobe
    latch(0);                                      // R6 reload same register
    load_ref(14'h1555, 1'b0, 1'b0, 1'b0, 1'b0);
    latch(3);                                      // R6 reload reference group
    latch(0);

    tick(20);
    chk(q.size() == 0, "R5", "pending loads", q.size(), 0);
    chk(dones == loads, "R5", "done count", dones, loads);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule